// File: doc/BRIEF.md
# Register File with Write Forwarding

This block holds a bank of general registers that an instruction stream reads and writes once per instruction. Each instruction names a register through a short local select. The select is joined with a region base, held in a small register of its own, to form the physical register address. Reloading the base moves the whole local window to another group of physical registers.

A write finishes late in the pipeline. It is captured in a one-entry staging register and reaches the storage array one instruction later. A read issued by the instruction directly after a write to the same physical register is served from the staging register, not from the array, so it returns the new value. The forwarding decision compares every bit of the full address, base bits included. A low-bit flag for branching on odd register values is taken from the same forwarded value.

Top module: `rfb_top`

## Requirements
- R1: After reset the region base is zero, no forwarding is pending, and every register reads as zero.
- R2: The physical address is the region base in the upper bits with the local select in the lower bits. Base 1 with select 3 and base 3 with select 1 are different registers.
- R3: A read in the instruction right after a write (`wr_en` high) to the same physical address returns the data just written.
- R4: When one unrelated instruction lies between a write and a read of the same register, the read returns the written value from the storage array.
- R5: A difference in any single address bit, in either the select or the base, prevents forwarding. The read then returns that register's own stored value.
- R6: Data and select presented with `wr_en` low modify no register and are never forwarded.
- R7: A base load (`base_ld` high) takes effect from the next instruction on. It covers both reads and writes. The loading instruction itself still uses the old base.
- R8: `rd_odd` equals bit 0 of the value returned on `rd_data`, including when that value is forwarded.
- R9: Back-to-back writes to one register are seen in order: each read returns the most recent earlier write.
- R10: A read in the same instruction as a write to the same register returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one instruction per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_sel | input | 4 | Local select of the register read |
| rd_data | output | 16 | Read value, forwarded or from the array |
| rd_odd | output | 1 | Odd-value branch condition of the read value |
| wr_en | input | 1 | Write request of this instruction |
| wr_sel | input | 4 | Local select of the register written |
| wr_data | input | 16 | Value to write |
| base_ld | input | 1 | Load the region base register |
| base_val | input | 4 | New region base value |

## Verification
The bench uses the default widths: 16-bit data, a 4-bit select and a 4-bit base. With these widths the 8-bit physical address is small enough to flip each of its bits one at a time. Each single-bit flip is placed in the instruction right after a write, once for each of the four select bits and once for each of the four base bits. The base flips are made by loading the new base in the writing instruction. The same setup also places reads at distances of zero, one and two instructions from a write, and includes back-to-back writes to one register. Values alternate between odd and even, so the branch flag is checked on both the forwarded path and the array path.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
    localparam int unsigned RFB_DATA_W = 16;
    localparam int unsigned RFB_SEL_W  = 4;
    localparam int unsigned RFB_BASE_W = 4;
endpackage

// File: rtl/rfb_addr_join.sv
module rfb_addr_join #(
    parameter int unsigned SEL_W  = 4,
    parameter int unsigned BASE_W = 4,
    localparam int unsigned ADDR_W = SEL_W + BASE_W
) (
    input  logic [BASE_W-1:0] base,
    input  logic [SEL_W-1:0]  sel,
    output logic [ADDR_W-1:0] addr
);
    // base occupies the upper bits, local select the lower bits
    assign addr = {base, sel};
endmodule

// File: rtl/rfb_store.sv
module rfb_store #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/rfb_fwd.sv
module rfb_fwd #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              stg_vld,
    input  logic [ADDR_W-1:0] stg_addr,
    input  logic [DATA_W-1:0] stg_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    output logic              hit,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_odd
);
    logic [ADDR_W-1:0] bit_eq;

    // every address bit is compared on its own
    for (genvar g = 0; g < ADDR_W; g++) begin : g_cmp
        assign bit_eq[g] = ~(stg_addr[g] ^ rd_addr[g]);
    end

    assign hit     = stg_vld & (&bit_eq);
    assign rd_data = hit ? stg_data : arr_data;
    assign rd_odd  = hit ? stg_data[0] : arr_data[0];
endmodule

// File: rtl/rfb_top.sv
module rfb_top
    import rfb_pkg::*;
#(
    parameter int unsigned DATA_W = RFB_DATA_W,
    parameter int unsigned SEL_W  = RFB_SEL_W,
    parameter int unsigned BASE_W = RFB_BASE_W,
    localparam int unsigned ADDR_W = SEL_W + BASE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_odd,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              base_ld,
    input  logic [BASE_W-1:0] base_val
);
    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              stg_vld;
        logic [ADDR_W-1:0] stg_addr;
        logic [DATA_W-1:0] stg_data;
    } state_t;

    state_t st_d, st_q;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] arr_data;
    logic              hit;

    rfb_addr_join #(.SEL_W(SEL_W), .BASE_W(BASE_W)) u_rd_join (
        .base(st_q.base), .sel(rd_sel), .addr(rd_addr)
    );
    rfb_addr_join #(.SEL_W(SEL_W), .BASE_W(BASE_W)) u_wr_join (
        .base(st_q.base), .sel(wr_sel), .addr(wr_addr)
    );

    always_comb begin
        st_d         = st_q;
        st_d.stg_vld = wr_en;
        if (wr_en) begin
            st_d.stg_addr = wr_addr;
            st_d.stg_data = wr_data;
        end
        if (base_ld) st_d.base = base_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // staged write retires into the array one instruction after capture
    rfb_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(st_q.stg_vld), .waddr(st_q.stg_addr), .wdata(st_q.stg_data),
        .raddr(rd_addr), .rdata(arr_data)
    );

    rfb_fwd #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fwd (
        .stg_vld(st_q.stg_vld), .stg_addr(st_q.stg_addr), .stg_data(st_q.stg_data),
        .rd_addr(rd_addr), .arr_data(arr_data),
        .hit(hit), .rd_data(rd_data), .rd_odd(rd_odd)
    );

    // R3: next-instruction read of the just-written register sees new data
    a_r3_fwd_new_data: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_addr != $past(wr_addr)) || (rd_data == $past(wr_data)));

    // R6: no write request, nothing to forward in the next instruction
    a_r6_no_fwd_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !hit);

    // R5: forwarding only on a full-address match
    a_r5_full_match: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (rd_addr == st_q.stg_addr));

    // R7: base load visible from the following instruction
    a_r7_base_load: assert property (@(posedge clk) disable iff (!rst_n)
        base_ld |=> (st_q.base == $past(base_val)));

    // R8: branch flag tracks the returned value
    a_r8_odd_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rd_odd == rd_data[0]);
endmodule

// File: tb/tb_rfb_top.sv
module tb_rfb_top;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        rd_odd;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        base_ld = 1'b0;
    logic [3:0]  base_val = '0;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [15:0] data;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    logic [15:0] model [256];
    logic [3:0]  base_m = '0;

    always #(PERIOD/2) clk = ~clk;

    rfb_top dut (
        .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .rd_data(rd_data), .rd_odd(rd_odd),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .base_ld(base_ld), .base_val(base_val)
    );

    // one instruction: drive, push the expected read, advance the model
    task automatic instr(input logic [3:0] rs, input logic we, input logic [3:0] ws,
                         input logic [15:0] wd, input logic bl, input logic [3:0] bv,
                         input string tag);
        exp_t e;
        @(negedge clk);
        rd_sel = rs; wr_en = we; wr_sel = ws; wr_data = wd; base_ld = bl; base_val = bv;
        e.data = model[{base_m, rs}];
        e.tag  = tag;
        sb_q.push_back(e);
        if (we) model[{base_m, ws}] = wd;
        if (bl) base_m = bv;
    endtask

    task automatic rd(input logic [3:0] rs, input string tag);
        instr(rs, 1'b0, 4'd0, 16'd0, 1'b0, 4'd0, tag);
    endtask

    // monitor
    always @(negedge clk) begin
        #(PERIOD/4);
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (rd_data !== e.data) begin
                fails++;
                $display("FAIL %s rd_data actual=%h expected=%h", e.tag, rd_data, e.data);
            end
            checks++;
            if (rd_odd !== e.data[0]) begin
                fails++;
                $display("FAIL R8 rd_odd actual=%b expected=%b", rd_odd, e.data[0]);
            end
        end
    end

    initial begin
        #(PERIOD*100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(4'd0, "R1"); rd(4'd5, "R1"); rd(4'd15, "R1");

        // R3: forwarding in the very next instruction
        instr(4'd0, 1'b1, 4'd3, 16'hA5A5, 1'b0, 4'd0, "R1");
        rd(4'd3, "R3");

        // R4: one unrelated instruction in between
        instr(4'd0, 1'b1, 4'd6, 16'h1234, 1'b0, 4'd0, "R4");
        rd(4'd0, "R4");
        rd(4'd6, "R4");

        // R6: disabled write must not forward nor store
        instr(4'd0, 1'b0, 4'd6, 16'hFFFF, 1'b0, 4'd0, "R6");
        rd(4'd6, "R6");
        rd(4'd6, "R6");

        // R5: single select-bit mismatch right after a write
        for (int i = 0; i < 4; i++) begin
            instr(4'd0, 1'b1, 4'd0, 16'hB000 + 16'(i), 1'b0, 4'd0, "R5");
            rd(4'(1 << i), "R5");
        end
        // R5: single base-bit mismatch, base reloaded in the writing instruction
        for (int j = 0; j < 4; j++) begin
            instr(4'd0, 1'b1, 4'd2, 16'hC000 + 16'(j), 1'b1, 4'(1 << j), "R5");
            rd(4'd2, "R5");
            instr(4'd0, 1'b0, 4'd0, 16'd0, 1'b1, 4'd0, "R5");
        end

        // R7: base reload moves the window; loading instruction uses old base
        instr(4'd2, 1'b1, 4'd2, 16'h5555, 1'b1, 4'd5, "R7");
        instr(4'd2, 1'b1, 4'd2, 16'h0777, 1'b1, 4'd0, "R7");
        rd(4'd2, "R7");
        instr(4'd0, 1'b0, 4'd0, 16'd0, 1'b1, 4'd5, "R7");
        rd(4'd2, "R7");

        // R2: {base,sel} ordering
        instr(4'd0, 1'b1, 4'd3, 16'h0103, 1'b1, 4'd1, "R2");
        instr(4'd0, 1'b0, 4'd0, 16'd0, 1'b1, 4'd3, "R2");
        instr(4'd0, 1'b1, 4'd1, 16'h0301, 1'b1, 4'd1, "R2");
        rd(4'd3, "R2");
        instr(4'd0, 1'b0, 4'd0, 16'd0, 1'b1, 4'd3, "R2");
        rd(4'd1, "R2");
        instr(4'd0, 1'b0, 4'd0, 16'd0, 1'b1, 4'd0, "R2");

        // R8: odd flag on the forwarded and array paths
        instr(4'd0, 1'b1, 4'd9, 16'h0003, 1'b0, 4'd0, "R8");
        rd(4'd9, "R8");
        instr(4'd0, 1'b1, 4'd9, 16'h0002, 1'b0, 4'd0, "R8");
        rd(4'd9, "R8");
        rd(4'd9, "R8");

        // R9: back-to-back writes, R10: same-instruction read sees old value
        instr(4'd4, 1'b1, 4'd4, 16'h1111, 1'b0, 4'd0, "R10");
        instr(4'd4, 1'b1, 4'd4, 16'h2223, 1'b0, 4'd0, "R9");
        rd(4'd4, "R9");
        rd(4'd4, "R9");

        rd(4'd0, "R1");
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule